// File: doc/BRIEF.md
# Accumulator-Clocked Noise Shift Register

This block produces the noise waveform for a phase-accumulator oscillator. It holds a 23-bit Fibonacci shift register whose feedback bit is bit 22 XOR bit 17. The register advances by one position only when a chosen accumulator bit, bit 19, goes from 0 to 1. The oscillator supplies that bit's value from the previous cycle and from the current cycle.

Eight register bits, scattered across the word, form an 8-bit noise value. That value is left-justified into a 12-bit registered output. A test control clears the register while it is high. When test falls, the register reloads a fixed nonzero seed, so the sequence always restarts from a known point.

Top module: `noise_lfsr`

## Requirements
- R1: After reset the register holds 0x7FFFF8, and one cycle later the output reads 0xFE0.
- R2: The register shifts only in a cycle where `acc_prev_i` is 0, `acc_cur_i` is 1 and test is low. With any other (prev, cur) pair the register holds its value.
- R3: On a shift every bit moves up one position. The new bit 0 is the old bit 22 XOR the old bit 17. Starting from the seed, the first shift gives 0x7FFFF0 and the second gives 0x7FFFE0.
- R4: Output bits 11 down to 4 come from register bits 22, 20, 16, 13, 11, 7, 4 and 2, in that order.
- R5: Output bits 3 to 0 are always zero.
- R6: In every cycle in which `test_i` is high, the register is loaded with zero, so the output reads 0x000.
- R7: In the first cycle with `test_i` low after a cycle with it high, the register loads 0x7FFFF8. This load takes precedence over a rising edge present in the same cycle.
- R8: A rising edge of accumulator bit 19 seen while `test_i` is high has no effect. The register stays zero, and after release the sequence restarts from the seed.
- R9: The output is a register. It shows the tap selection of the register value as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_i | input | 1 | Test control: clears the register while high, reloads the seed on release |
| acc_prev_i | input | 1 | Accumulator bit 19 from the previous cycle |
| acc_cur_i | input | 1 | Accumulator bit 19 in the current cycle |
| noise_o | output | 12 | Registered noise value in bits 11:4, zero in bits 3:0 |

## Verification
The bench drives all four (prev, cur) combinations many thousands of times. A design that also shifted on a falling edge, or on a level, would quickly drift off the expected sequence.

The two-shift value 0xFC0 is checked explicitly. A wrong feedback tap or a misordered output tap would change that value, or a later one.

Test pulses are placed on top of active rising edges, and one test release coincides with an edge. A design that shifted during test, or let a shift override the seed load, would then show a nonzero value while test is high, or a shifted seed after release. An output taken straight from the register, instead of through a register, would appear one cycle early.

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int LEN = 23,
  parameter int FB_HI = 22,
  parameter int FB_LO = 17,
  parameter int OUT_W = 12,
  parameter logic [LEN-1:0] SEED = 23'h7FFFF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_i,
  input  logic             acc_prev_i,
  input  logic             acc_cur_i,
  output logic [OUT_W-1:0] noise_o
);
  localparam int PAD = OUT_W - 8;

  logic [LEN-1:0] lfsr_q;
  logic           test_q;
  logic           rise;
  logic [7:0]     taps;

  assign rise = ~acc_prev_i & acc_cur_i & ~test_i;
  assign taps = {lfsr_q[22], lfsr_q[20], lfsr_q[16], lfsr_q[13],
                 lfsr_q[11], lfsr_q[7],  lfsr_q[4],  lfsr_q[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q  <= SEED;
      test_q  <= 1'b0;
      noise_o <= '0;
    end else begin
      test_q  <= test_i;
      noise_o <= {taps, {PAD{1'b0}}};
      if (test_i)
        lfsr_q <= '0;
      else if (test_q)
        lfsr_q <= SEED;
      else if (rise)
        lfsr_q <= {lfsr_q[LEN-2:0], lfsr_q[FB_HI] ^ lfsr_q[FB_LO]};
    end
  end
endmodule

// File: rtl/noise_lfsr_chk.sv
module noise_lfsr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        test_i,
  input logic        acc_prev_i,
  input logic        acc_cur_i,
  input logic [22:0] lfsr,
  input logic [11:0] noise_o
);
  function automatic logic [7:0] sel(input logic [22:0] r);
    return {r[22], r[20], r[16], r[13], r[11], r[7], r[4], r[2]};
  endfunction

  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  assert_clear_in_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    test_i |=> (lfsr == 23'h0));

  assert_seed_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (!test_i && $past(test_i)) |=> (lfsr == 23'h7FFFF8));

  assert_hold_without_edge_R2: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (!test_i && !$past(test_i) && !(!acc_prev_i && acc_cur_i)) |=> $stable(lfsr));

  assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (!test_i && !$past(test_i) && !acc_prev_i && acc_cur_i) |=>
      (lfsr == {$past(lfsr[21:0]), $past(lfsr[22]) ^ $past(lfsr[17])}));

  assert_out_registered_R9: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    1'b1 |=> (noise_o[11:4] == sel($past(lfsr))));

  assert_low_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    noise_o[3:0] == 4'h0);
endmodule

bind noise_lfsr noise_lfsr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .test_i(test_i), .acc_prev_i(acc_prev_i),
  .acc_cur_i(acc_cur_i), .lfsr(lfsr_q), .noise_o(noise_o)
);

// File: tb/sim_noise_lfsr.sv
module sim_noise_lfsr;
  logic clk = 0, rst_n = 0, test = 0, prv = 0, cur = 0;
  logic [11:0] out;
  int n_chk = 0, n_bad = 0;
  logic [22:0] m;
  logic m_tq;

  always #2.5 clk = ~clk;

  noise_lfsr u0 (.clk(clk), .rst_n(rst_n), .test_i(test), .acc_prev_i(prv),
                 .acc_cur_i(cur), .noise_o(out));

  function automatic logic [11:0] expo(input logic [22:0] r);
    return {r[22], r[20], r[16], r[13], r[11], r[7], r[4], r[2], 4'h0};
  endfunction

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %03h expected %03h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic p, input logic c, input string req);
    logic [11:0] e;
    test = t; prv = p; cur = c;
    @(posedge clk);
    e = expo(m);
    if (t) m = '0;
    else if (m_tq) m = 23'h7FFFF8;
    else if (!p && c) m = {m[21:0], m[22] ^ m[17]};
    m_tq = t;
    @(negedge clk);
    check(req, out, e);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m = 23'h7FFFF8; m_tq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset output", out, 12'hFE0);
    step(0, 0, 1, "R3 first shift");
    step(0, 0, 1, "R3 second shift");
    step(0, 0, 0, "R3 after two shifts");
    check("R3/R4 value after two shifts", out, 12'hFC0);
    for (int i = 0; i < 8; i++) step(0, i[0], i[1], "R2 combo sweep");
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[7:3] == 0, r[0], r[1], "R2/R3/R4/R9 sweep");
      check("R5 low nibble", {8'h0, out[3:0]}, 12'h0);
    end
    step(0, 0, 1, "R2 before test");
    step(1, 0, 1, "R8 edge in test");
    step(1, 0, 1, "R8 edge in test");
    step(1, 0, 0, "R6 test held");
    check("R6 zero while test", out, 12'h000);
    step(0, 0, 1, "R7 release with edge");
    step(0, 1, 1, "R7 seed visible");
    check("R7 seed after release", out, 12'hFE0);
    step(0, 0, 1, "R9 shift");
    step(0, 0, 1, "R9 shift");
    step(0, 0, 0, "R9 settle");
    check("R9 two shifts after seed", out, 12'hFC0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule